// File: doc/BRIEF.md
# Board Control Register Block

A 32-bit register block that a processor reaches over a simple memory-mapped bus with separate read and write strobes. Only the low 20 bits of the address are decoded, so the block repeats across any larger window the system gives it. It holds the following:

- a byte that drives an LED bar;
- an eight-character ASCII display buffer;
- a break/reset byte and a general-purpose output byte;
- a small group of bit-bang I2C control registers that drive the clock and data lines of a serial EEPROM.

A write of one magic value to the soft-reset offset raises a one-cycle system reset request. Fixed switch, jumper and status words can be read back.

The display buffer can be loaded in two ways. A single word write turns a 32-bit value into eight uppercase hexadecimal characters. Writes to eight per-character offsets, spaced 8 bytes apart, each place one character. The buffer leaves the block as a flat 64-bit port, with character i in bits [8i+7:8i]. A one-cycle change pulse follows any write that alters the buffer's contents.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the registers hold these values: LED 0x00, break 0x0a, general output 0x00, I2C output enable 0x0, I2C output 0x3, I2C select 0x1. Every display character is 0x20, and both I2C lines are high.
- R2: Only address bits [19:0] are decoded. An access to 0xFFF00408 behaves exactly like an access to 0x00408.
- R3: The switch word (0x00200) and the jumper word (0x00210) always read 0, and writes to them change nothing. Any unmapped offset reads 0.
- R4: The status word at 0x00208 reads 0x12 when parameter BIG_ENDIAN is 1 and 0x10 when it is 0.
- R5: The LED register (0x00408), the break register (0x00508) and the general output register (0x00a00) each keep bits [7:0] of a write and read back with the upper bits zero.
- R6: A write to 0x00410 loads all eight display characters as uppercase hexadecimal ASCII ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46). Character 0 comes from bits [31:28], and character 7 comes from bits [3:0].
- R7: A write to 0x00418 + 8*i, for i from 0 to 7, stores bits [7:0] of the data into character i and leaves the other characters unchanged.
- R8: A write of exactly 0x42 to 0x00500 sets reset_req high for one cycle, on the cycle after the write. Any other value written there leaves reset_req low.
- R9: The I2C output enable register (0x00b08) keeps 2 bits, and the I2C select register (0x00b18) keeps 1 bit. The I2C output register (0x00b10) keeps the full word, with bit 1 driving i2c_scl and bit 0 driving i2c_sda.
- R10: The general input word (0x00a08) reads as the I2C output register when I2C select is 1 and reads 0 when it is 0.
- R11: The I2C input word (0x00b00) reads as the stored input bits (0x3), with bit 0 replaced by the live eeprom_sda line.
- R12: rdata is loaded on the clock edge that samples rd_en and holds its value while rd_en is low.
- R13: disp_changed is high for exactly one cycle after a display write that changes at least one character. It stays low after a display write that leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Byte address; bits [19:0] are decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eeprom_sda | input | 1 | Live data line returned by the EEPROM |
| reset_req | output | 1 | One-cycle system reset request |
| led_bar | output | 8 | LED bar byte |
| i2c_scl | output | 1 | I2C clock line (bit 1 of the I2C output register) |
| i2c_sda | output | 1 | I2C data line (bit 0 of the I2C output register) |
| disp_chars | output | 64 | Display buffer, character i at [8i+7:8i] |
| disp_changed | output | 1 | One-cycle pulse after a display content change |

## Verification
The bench builds two copies of the block that share every input. The first copy uses BIG_ENDIAN set to 1 and carries all the tests. The second copy uses the default of 0, so both status encodings can be checked in the same run. Directed tasks cover the hex conversion with digits and letters, each per-character stride offset, the near-miss values at the soft-reset offset, the select-gated loop-back to the general input word, and a display write that does not alter the buffer and so must produce no change pulse.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter bit BIG_ENDIAN = 1'b0,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NCHAR      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               eeprom_sda,
  output logic               reset_req,
  output logic [7:0]         led_bar,
  output logic               i2c_scl,
  output logic               i2c_sda,
  output logic [8*NCHAR-1:0] disp_chars,
  output logic               disp_changed
);
  localparam int OW = 20;
  localparam logic [OW-1:0] A_SWITCH = 20'h00200;
  localparam logic [OW-1:0] A_STATUS = 20'h00208;
  localparam logic [OW-1:0] A_JUMPER = 20'h00210;
  localparam logic [OW-1:0] A_LED    = 20'h00408;
  localparam logic [OW-1:0] A_HEX    = 20'h00410;
  localparam logic [OW-1:0] A_CHAR0  = 20'h00418;
  localparam logic [OW-1:0] A_CHARN  = A_CHAR0 + OW'(8*(NCHAR-1));
  localparam logic [OW-1:0] A_SOFT   = 20'h00500;
  localparam logic [OW-1:0] A_BRK    = 20'h00508;
  localparam logic [OW-1:0] A_GPOUT  = 20'h00a00;
  localparam logic [OW-1:0] A_GPIN   = 20'h00a08;
  localparam logic [OW-1:0] A_I2CIN  = 20'h00b00;
  localparam logic [OW-1:0] A_I2COE  = 20'h00b08;
  localparam logic [OW-1:0] A_I2COUT = 20'h00b10;
  localparam logic [OW-1:0] A_I2CSEL = 20'h00b18;
  localparam logic [DW-1:0] STATUS_V = BIG_ENDIAN ? DW'(32'h12) : DW'(32'h10);
  localparam logic [DW-1:0] I2CIN_V  = DW'(32'h3);
  localparam int CW = $clog2(NCHAR);

  logic [OW-1:0] off;
  logic [7:0]    led_q, brk_q, gpout_q;
  logic [1:0]    i2coe_q;
  logic          i2csel_q;
  logic [DW-1:0] i2cout_q, rd_mux;
  logic [8*NCHAR-1:0] disp_nx;
  logic [OW-1:0] cdiff;
  logic [CW-1:0] cidx;
  logic          char_hit, hex_hit;

  assign off      = addr[OW-1:0];
  assign cdiff    = off - A_CHAR0;
  assign cidx     = cdiff[CW+2:3];
  assign char_hit = wr_en && off >= A_CHAR0 && off <= A_CHARN && off[2:0] == 3'd0;
  assign hex_hit  = wr_en && off == A_HEX;
  assign led_bar  = led_q;
  assign i2c_scl  = i2cout_q[1];
  assign i2c_sda  = i2cout_q[0];

  function automatic logic [7:0] to_hex(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'd0, n} : 8'h37 + {4'd0, n};
  endfunction

  always_comb begin
    disp_nx = disp_chars;
    if (hex_hit)
      for (int i = 0; i < NCHAR; i++)
        disp_nx[8*i +: 8] = to_hex(wdata[DW-4-4*i +: 4]);
    if (char_hit)
      disp_nx[8*cidx +: 8] = wdata[7:0];
  end

  always_comb begin
    case (off)
      A_STATUS: rd_mux = STATUS_V;
      A_LED:    rd_mux = DW'(led_q);
      A_BRK:    rd_mux = DW'(brk_q);
      A_GPOUT:  rd_mux = DW'(gpout_q);
      A_GPIN:   rd_mux = i2csel_q ? i2cout_q : '0;
      A_I2CIN:  rd_mux = {I2CIN_V[DW-1:1], eeprom_sda};
      A_I2COE:  rd_mux = DW'(i2coe_q);
      A_I2COUT: rd_mux = i2cout_q;
      A_I2CSEL: rd_mux = DW'(i2csel_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q        <= 8'h00;
      brk_q        <= 8'h0a;
      gpout_q      <= 8'h00;
      i2coe_q      <= 2'd0;
      i2cout_q     <= DW'(32'h3);
      i2csel_q     <= 1'b1;
      disp_chars   <= {NCHAR{8'h20}};
      disp_changed <= 1'b0;
      reset_req    <= 1'b0;
      rdata        <= '0;
    end else begin
      disp_chars   <= disp_nx;
      disp_changed <= (hex_hit || char_hit) && (disp_nx != disp_chars);
      reset_req    <= wr_en && off == A_SOFT && wdata == DW'(32'h42);
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        case (off)
          A_LED:    led_q    <= wdata[7:0];
          A_BRK:    brk_q    <= wdata[7:0];
          A_GPOUT:  gpout_q  <= wdata[7:0];
          A_I2COE:  i2coe_q  <= wdata[1:0];
          A_I2COUT: i2cout_q <= wdata;
          A_I2CSEL: i2csel_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R8
  soft_reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en && addr[OW-1:0] == A_SOFT && wdata == DW'(32'h42)));

  // R9
  i2c_line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == A_I2COUT) |=> (i2c_scl == $past(wdata[1]) && i2c_sda == $past(wdata[0])));

  // R13
  disp_change_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_changed |-> (disp_chars != $past(disp_chars)));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R3
  switch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (off == A_SWITCH || off == A_JUMPER)) |=> rdata == '0);
endmodule

// File: tb/sim_board_ctrl_regs.sv
module sim_board_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, eeprom_sda = 0;
  logic [31:0] addr = 0, wdata = 0, rdata, rdata_le;
  logic reset_req, i2c_scl, i2c_sda, disp_changed;
  logic reset_req_le, scl_le, sda_le, chg_le;
  logic [7:0] led_bar, led_le;
  logic [63:0] disp_chars, disp_le;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctrl_regs #(.BIG_ENDIAN(1'b1)) u0 (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .eeprom_sda,
    .reset_req, .led_bar, .i2c_scl, .i2c_sda, .disp_chars, .disp_changed);

  board_ctrl_regs u1 (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata(rdata_le), .eeprom_sda,
    .reset_req(reset_req_le), .led_bar(led_le), .i2c_scl(scl_le), .i2c_sda(sda_le),
    .disp_chars(disp_le), .disp_changed(chg_le));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 disp", disp_chars, {8{8'h20}});
    check("R1 scl/sda", {i2c_scl, i2c_sda}, 2'b11);
    rd(32'h408, v); check("R1 led", v, 0);
    rd(32'h508, v); check("R1 brk", v, 32'h0a);
    rd(32'ha00, v); check("R1 gpout", v, 0);
    rd(32'hb08, v); check("R1 i2coe", v, 0);
    rd(32'hb10, v); check("R1 i2cout", v, 3);
    rd(32'hb18, v); check("R1 i2csel", v, 1);
  endtask

  task automatic t_nochange;
    wr(32'h418, 32'h20);
    check("R13 no pulse on same char", disp_changed, 0);
    wr(32'h420, 32'h5A);
    check("R13 pulse", disp_changed, 1);
    @(negedge clk);
    check("R13 pulse one cycle", disp_changed, 0);
  endtask

  task automatic t_fixed;
    logic [31:0] v;
    wr(32'h200, 32'hFFFF_FFFF); rd(32'h200, v); check("R3 switch", v, 0);
    wr(32'h210, 32'h1234); rd(32'h210, v); check("R3 jumper", v, 0);
    rd(32'h300, v); check("R3 unmapped", v, 0);
    rd(32'h208, v); check("R4 status BE", v, 32'h12);
    check("R4 status LE", rdata_le, 32'h10);
  endtask

  task automatic t_bytes;
    logic [31:0] v;
    wr(32'h408, 32'hABCD_12C3); rd(32'h408, v); check("R5 led", v, 32'hC3);
    check("R5 led port", led_bar, 8'hC3);
    wr(32'h508, 32'h0000_FF5E); rd(32'h508, v); check("R5 brk", v, 32'h5E);
    wr(32'ha00, 32'h8000_0077); rd(32'ha00, v); check("R5 gpout", v, 32'h77);
    wr(32'hFFF0_0408, 32'h11); rd(32'h408, v); check("R2 alias write", v, 32'h11);
    rd(32'h7AB0_0508, v); check("R2 alias read", v, 32'h5E);
  endtask

  task automatic t_display;
    wr(32'h410, 32'h1234_ABCD);
    check("R6 hex", disp_chars, {8'h44,8'h43,8'h42,8'h41,8'h34,8'h33,8'h32,8'h31});
    check("R13 hex pulse", disp_changed, 1);
    wr(32'h410, 32'hF09E_0000);
    check("R6 hex2", disp_chars, {8'h30,8'h30,8'h30,8'h30,8'h45,8'h39,8'h30,8'h46});
    for (int i = 0; i < 8; i++) wr(32'h418 + 32'(8*i), 32'hFF00 + 32'(8'h61 + i));
    check("R7 all chars", disp_chars, {8'h68,8'h67,8'h66,8'h65,8'h64,8'h63,8'h62,8'h61});
    wr(32'h448, 32'h2A);
    check("R7 char6 only", disp_chars, {8'h68,8'h2A,8'h66,8'h65,8'h64,8'h63,8'h62,8'h61});
    wr(32'h41C, 32'h00);
    check("R7 off-stride ignored", disp_chars, {8'h68,8'h2A,8'h66,8'h65,8'h64,8'h63,8'h62,8'h61});
  endtask

  task automatic t_softreset;
    wr(32'h500, 32'h43); check("R8 non-magic", reset_req, 0);
    wr(32'h500, 32'h142); check("R8 upper bits", reset_req, 0);
    wr(32'h504, 32'h42); check("R8 wrong offset", reset_req, 0);
    wr(32'h500, 32'h42); check("R8 pulse", reset_req, 1);
    @(negedge clk); check("R8 one cycle", reset_req, 0);
  endtask

  task automatic t_i2c;
    logic [31:0] v;
    wr(32'hb08, 32'hF); rd(32'hb08, v); check("R9 oe 2 bits", v, 3);
    wr(32'hb18, 32'hE); rd(32'hb18, v); check("R9 sel 1 bit", v, 0);
    wr(32'hb10, 32'hC0DE_0002);
    check("R9 lines", {i2c_scl, i2c_sda}, 2'b10);
    rd(32'hb10, v); check("R9 full word", v, 32'hC0DE_0002);
    rd(32'ha08, v); check("R10 gpin sel0", v, 0);
    wr(32'hb18, 32'h1); rd(32'ha08, v); check("R10 gpin sel1", v, 32'hC0DE_0002);
    wr(32'hb10, 32'h1);
    check("R9 lines2", {i2c_scl, i2c_sda}, 2'b01);
    eeprom_sda = 0; rd(32'hb00, v); check("R11 sda0", v, 2);
    eeprom_sda = 1; rd(32'hb00, v); check("R11 sda1", v, 3);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    rd(32'h508, v); check("R12 read", v, 32'h5E);
    addr = 32'h408; repeat (3) @(negedge clk);
    check("R12 hold", rdata, 32'h5E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_nochange();
    t_fixed();
    t_bytes();
    t_display();
    t_softreset();
    t_i2c();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule